// File: doc/BRIEF.md
# Stereo ADC Power-Down and Start-Up Sequencer

This block sits in the digital back end of a stereo audio ADC. It decides whether converted samples may leave the block, and it protects the control register bank across power transitions. Two sources can power the converter down: an active-low pin and a power-management bit. When either one releases, a start-up window begins. That window is counted in frame-clock periods. During the window, and during any power-down, both channels present two's-complement zero and `data_valid_o` stays low.

The pin does more than the bit. Holding it low returns every control register to its default value. The first start-up after a pin release also refuses writes to one protected register address. Separately, all writes are refused while the external clocks are reported absent.

Frame-clock ticks arrive as one-cycle enables in the system clock domain. A read port shows the register contents. A one-cycle strobe marks every write that was accepted.

Top module: `adc_pwr_seq`

## Requirements
- R1: After `rst_ni` is asserted, `state_o` reads 0 (pin power-down), both sample outputs are zero, `data_valid_o` is 0, and register i reads `(0xA5 XOR (i*0x13)) mod 256`.
- R2: Suppose `pdn_ni` is high and `pm_i` is high while `state_o` is 0. Then `state_o` becomes 2 (initializing) after the next edge. It becomes 3 (normal) on the edge that takes the INIT_FRAMES-th `tick_i` pulse seen in state 2. Cycles without a tick do not advance the count.
- R3: Outside state 3, `left_o` and `right_o` are zero and `data_valid_o` is 0. In state 3, the raw samples pass through unchanged and `data_valid_o` is 1.
- R4: With `pdn_ni` high, `pm_i` low in state 2 or 3 gives state 1 (bit power-down) after the next edge. Raising `pm_i` in state 1 gives state 2, and that start-up needs a full INIT_FRAMES ticks.
- R5: `pdn_ni` low gives state 0 after the next edge from any state, including part-way through a start-up. It discards the partial count and returns every register to its default value.
- R6: During a start-up entered from a pin release, a write to address 1 is refused: there is no strobe and the value does not change. Writes to other addresses are accepted.
- R7: While `clk_ok_i` is 0, every write is refused: there is no strobe and no register changes.
- R8: An accepted write updates the addressed register and raises `wr_ack_o` for exactly one cycle after the write cycle. A write while `pdn_ni` is low, or in state 0, is refused.
- R9: Suppose `pdn_ni` rises while `pm_i` is low. Then state 0 goes to state 1, not to state 2.
- R10: During a start-up entered from state 1 after a normal period, a write to address 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdn_ni | input | 1 | Active-low power-down pin |
| pm_i | input | 1 | Power-management enable bit (0 = powered down) |
| tick_i | input | 1 | One-cycle frame-clock enable |
| clk_ok_i | input | 1 | External clocks present |
| wr_en_i | input | 1 | Register write request |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Register contents at rd_addr_i |
| left_raw_i | input | SAMPLE_W | Left channel raw sample |
| right_raw_i | input | SAMPLE_W | Right channel raw sample |
| left_o | output | SAMPLE_W | Gated left sample |
| right_o | output | SAMPLE_W | Gated right sample |
| data_valid_o | output | 1 | High only in normal state |
| state_o | output | 2 | 0 pin power-down, 1 bit power-down, 2 initializing, 3 normal |
| wr_ack_o | output | 1 | One-cycle accepted-write strobe |

## Verification
The bench builds the block with its default parameters. INIT_FRAMES is 4128, which makes the counter 13 bits wide, so the real start-up length is tested. The bench checks the exact boundary between tick 4127 and tick 4128, both with and without idle gaps between ticks. With eight 8-bit registers, the protected address 1 can be compared against an unprotected neighbour in the same start-up window. The default-value formula can also be checked after a pin power-down part-way through a count.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    ST_PIN_PD = 2'd0,
    ST_PM_PD  = 2'd1,
    ST_INIT   = 2'd2,
    ST_RUN    = 2'd3
  } pwr_state_e;

  // default value of control register idx (truncated by the user)
  function automatic logic [31:0] reg_default(int unsigned idx);
    return 32'h0000_00A5 ^ (idx * 32'h13);
  endfunction
endpackage

// File: rtl/adc_init_fsm.sv
module adc_init_fsm
  import adc_pwr_pkg::*;
#(
  parameter int unsigned INIT_FRAMES = 4128,
  localparam int unsigned CNT_W = $clog2(INIT_FRAMES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pdn_ni,
  input  logic       pm_i,
  input  logic       tick_i,
  output pwr_state_e state_o,
  output logic       prot_win_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_FRAMES - 1);

  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pin_init_q, pin_init_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    pin_init_d = pin_init_q;
    if (!pdn_ni) begin
      state_d    = ST_PIN_PD;
      cnt_d      = '0;
      pin_init_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_PIN_PD: begin
          pin_init_d = 1'b1;
          cnt_d      = '0;
          state_d    = pm_i ? ST_INIT : ST_PM_PD;
        end
        ST_PM_PD: begin
          cnt_d = '0;
          if (pm_i) state_d = ST_INIT;
        end
        ST_INIT: begin
          if (!pm_i) begin
            state_d = ST_PM_PD;
            cnt_d   = '0;
          end else if (tick_i) begin
            if (cnt_q == LAST) begin
              state_d    = ST_RUN;
              cnt_d      = '0;
              pin_init_d = 1'b0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RUN: if (!pm_i) state_d = ST_PM_PD;
        default: state_d = ST_PIN_PD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PIN_PD;
      cnt_q      <= '0;
      pin_init_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      pin_init_q <= pin_init_d;
    end
  end

  assign state_o    = state_q;
  assign prot_win_o = pin_init_q && (state_q == ST_INIT);
endmodule

// File: rtl/adc_reg_bank.sv
module adc_reg_bank
  import adc_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PROT_ADDR = 1,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdn_ni,
  input  logic              clk_ok_i,
  input  pwr_state_e        state_i,
  input  logic              prot_win_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_ack_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              accept;
  logic              ack_q;

  assign accept = wr_en_i && clk_ok_i && pdn_ni && (state_i != ST_PIN_PD) &&
                  !(prot_win_i && (wr_addr_i == ADDR_W'(PROT_ADDR)));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF = DATA_W'(reg_default(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       regs_q[g] <= DEF;
      else if (!pdn_ni)                                  regs_q[g] <= DEF;
      else if (accept && (wr_addr_i == ADDR_W'(g)))      regs_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= accept;
  end

  assign rd_data_o = regs_q[rd_addr_i];
  assign wr_ack_o  = ack_q;
endmodule

// File: rtl/adc_out_gate.sv
module adc_out_gate #(
  parameter int unsigned SAMPLE_W = 20
) (
  input  logic                run_i,
  input  logic [SAMPLE_W-1:0] left_raw_i,
  input  logic [SAMPLE_W-1:0] right_raw_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                data_valid_o
);
  assign left_o       = run_i ? left_raw_i  : '0;
  assign right_o      = run_i ? right_raw_i : '0;
  assign data_valid_o = run_i;
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int unsigned INIT_FRAMES = 4128,
  parameter int unsigned SAMPLE_W    = 20,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROT_ADDR   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pdn_ni,
  input  logic                pm_i,
  input  logic                tick_i,
  input  logic                clk_ok_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [SAMPLE_W-1:0] left_raw_i,
  input  logic [SAMPLE_W-1:0] right_raw_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                data_valid_o,
  output logic [1:0]          state_o,
  output logic                wr_ack_o
);
  pwr_state_e state;
  logic       prot_win;

  adc_init_fsm #(.INIT_FRAMES(INIT_FRAMES)) u_fsm (
    .clk_i, .rst_ni, .pdn_ni, .pm_i, .tick_i,
    .state_o(state), .prot_win_o(prot_win)
  );

  adc_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_ADDR(PROT_ADDR)) u_regs (
    .clk_i, .rst_ni, .pdn_ni, .clk_ok_i,
    .state_i(state), .prot_win_i(prot_win),
    .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o, .wr_ack_o
  );

  // pin low gates output immediately, ahead of the state register
  adc_out_gate #(.SAMPLE_W(SAMPLE_W)) u_gate (
    .run_i(pdn_ni && (state == ST_RUN)),
    .left_raw_i, .right_raw_i, .left_o, .right_o, .data_valid_o
  );

  assign state_o = state;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int unsigned SAMPLE_W = 20,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pdn_ni,
  input logic                pm_i,
  input logic                tick_i,
  input logic                clk_ok_i,
  input logic                wr_en_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                data_valid_o,
  input logic [1:0]          state_o,
  input logic                wr_ack_o
);
  // R3
  valid_only_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> state_o == 2'd3);
  // R3
  zero_when_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> (left_o == '0 && right_o == '0));
  // R2
  init_holds_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && !tick_i && pdn_ni && pm_i) |=> state_o == 2'd2);
  // R4
  pm_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[1] && pdn_ni && !pm_i) |=> state_o == 2'd1);
  // R5
  pin_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |=> state_o == 2'd0);
  // R7
  no_ack_without_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> ($past(clk_ok_i) && $past(wr_en_i) && $past(pdn_ni)));
  // R8
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ack_o && !$past(wr_en_i, 1)) |-> 1'b0);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;
  localparam int unsigned NF = 4128;
  localparam int unsigned SW = 20;

  logic clk = 0, rst_ni = 0;
  logic pdn_ni = 0, pm_i = 1, tick_i = 0, clk_ok_i = 1, wr_en_i = 0;
  logic [2:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic [SW-1:0] left_raw_i = 20'h7FFFF, right_raw_i = 20'h80001, left_o, right_o;
  logic data_valid_o, wr_ack_o;
  logic [1:0] state_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_pwr_seq u0 (.clk_i(clk), .rst_ni, .pdn_ni, .pm_i, .tick_i, .clk_ok_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .left_raw_i, .right_raw_i, .left_o, .right_o, .data_valid_o, .state_o, .wr_ack_o);

  function automatic logic [7:0] dflt(int i);
    return 8'hA5 ^ 8'(i * 19);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic ticks(int n);
    tick_i = 1;
    step(n);
    tick_i = 0;
  endtask

  task automatic rd(int a, output logic [7:0] v);
    rd_addr_i = 3'(a);
    #0.1;
    v = rd_data_o;
  endtask

  // issue one write; returns ack seen after the edge
  task automatic wr(int a, logic [7:0] d, output bit ack);
    wr_en_i = 1; wr_addr_i = 3'(a); wr_data_i = d;
    step();
    wr_en_i = 0;
    ack = wr_ack_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bit okd = 1;
    chk(state_o == 2'd0, "R1 state", state_o, 0);
    chk(left_o == 0 && right_o == 0 && !data_valid_o, "R1 outputs", left_o, 0);
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      if (v != dflt(i)) okd = 0;
    end
    chk(okd, "R1 defaults", 0, 0);
  endtask

  task automatic t_pin_write();
    bit a;
    logic [7:0] v;
    wr(2, 8'h3C, a);
    rd(2, v);
    chk(!a && v == dflt(2), "R8 write in pin power-down", v, dflt(2));
  endtask

  task automatic t_full_init();
    logic [7:0] v;
    bit a;
    pdn_ni = 1; pm_i = 1;
    step();
    chk(state_o == 2'd2, "R2 enter init", state_o, 2);
    wr(1, 8'h11, a);
    rd(1, v);
    chk(!a && v == dflt(1), "R6 addr1 refused", v, dflt(1));
    wr(2, 8'h5E, a);
    rd(2, v);
    chk(a && v == 8'h5E, "R8 addr2 accepted", v, 8'h5E);
    step();
    chk(!wr_ack_o, "R8 strobe one cycle", wr_ack_o, 0);
    clk_ok_i = 0;
    wr(3, 8'h77, a);
    rd(3, v);
    chk(!a && v == dflt(3), "R7 clocks absent", v, dflt(3));
    clk_ok_i = 1;
    ticks(2000);
    step(50);
    ticks(NF - 2001);
    chk(state_o == 2'd2 && !data_valid_o && left_o == 0, "R3 zero during init", state_o, 2);
    ticks(1);
    chk(state_o == 2'd3, "R2 normal after last tick", state_o, 3);
    chk(data_valid_o && left_o == left_raw_i && right_o == right_raw_i, "R3 pass-through", left_o, left_raw_i);
  endtask

  task automatic t_pm_cycle();
    bit a;
    logic [7:0] v;
    pm_i = 0;
    step();
    chk(state_o == 2'd1 && !data_valid_o, "R4 bit power-down", state_o, 1);
    pm_i = 1;
    step();
    chk(state_o == 2'd2, "R4 re-init", state_o, 2);
    wr(1, 8'h42, a);
    rd(1, v);
    chk(a && v == 8'h42, "R10 addr1 writable", v, 8'h42);
    ticks(NF - 1);
    chk(state_o == 2'd2, "R4 full count needed", state_o, 2);
    ticks(1);
    chk(state_o == 2'd3, "R4 normal again", state_o, 3);
  endtask

  task automatic t_pin_abort();
    logic [7:0] v;
    pdn_ni = 0;
    #0.1;
    chk(!data_valid_o && left_o == 0, "R5 immediate gating", left_o, 0);
    step();
    chk(state_o == 2'd0, "R5 pin power-down", state_o, 0);
    rd(2, v);
    chk(v == dflt(2), "R5 regs default", v, dflt(2));
    pdn_ni = 1;
    step();
    ticks(1000);
    pdn_ni = 0;
    step();
    chk(state_o == 2'd0, "R5 abort mid-count", state_o, 0);
    pdn_ni = 1;
    step();
    ticks(NF - 1);
    chk(state_o == 2'd2, "R5 count cleared", state_o, 2);
    ticks(1);
    chk(state_o == 2'd3, "R5 normal after full count", state_o, 3);
  endtask

  task automatic t_pin_release_pm_low();
    pdn_ni = 0;
    step();
    pm_i = 0; pdn_ni = 1;
    step();
    chk(state_o == 2'd1, "R9 release with pm low", state_o, 1);
    pm_i = 1;
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_ni = 1;
        step();
        t_reset();
        t_pin_write();
        t_full_init();
        t_pm_cycle();
        t_pin_abort();
        t_pin_release_pm_low();
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_run++;
          n_fail++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule